// File: doc/BRIEF.md
# Interrupt Flag and Mask Unit

This block gathers interrupt events into a small flag register, qualifies them with a software-written mask, and holds the global interrupt enable for a small microcontroller core. It has three hardware sources. A timer overflow pulse sets one flag. A falling edge on the external interrupt pin, after synchronisation, sets another. Any change on the general-purpose port pins while the device is asleep sets a third. Software may clear flags, but only hardware events can set them. Reads of the flag register return only the flags whose mask bit is set.

The core sees a registered interrupt request when the global enable is on and at least one unmasked flag is pending. Enable, return and disable strobes from instruction decode drive the global enable. The enable is also dropped automatically when the core accepts an interrupt. A registered wake-up output tells the power controller to leave sleep. It fires on a port change measured against a snapshot taken at sleep entry, or on any unmasked pending flag, whatever the global enable.

Top module: `irq_flag_unit`

## Requirements
- R1: After synchronous reset, the flags, the mask, the global enable, the interrupt request, the wake-up output and the read data are all zero.
- R2: A high-to-low transition on `ext_pin` sets flag bit 1, after a two-stage synchroniser. A low-to-high transition sets no flag.
- R3: A one-cycle high on `tmr_ovf` sets flag bit 0.
- R4: A flag write clears each flag bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. A write never sets a flag.
- R5: When a hardware set and a software clear hit the same flag bit in the same cycle, the bit ends up set.
- R6: `flag_rd` equals the flag register ANDed bitwise with the mask register, one cycle after either changes. `mask_wr` loads the mask from `mask_wdata`.
- R7: `en_stb` or `ret_stb` sets the global enable. `dis_stb` or `irq_ack` clears it, and clearing wins when both kinds of strobe occur in one cycle.
- R8: `irq_req` is high exactly one cycle after a cycle in which the global enable was 1 and at least one flag-AND-mask bit was 1.
- R9: While `sleep` is held, a difference between the synchronised port and the copy latched when `sleep` rose sets flag bit 2. A port change while `sleep` is low sets no flag.
- R10: `wake` is high one cycle after a cycle in which `sleep` was 1 and either a port change was seen or a flag-AND-mask bit was 1. This holds whatever the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| port_in | input | PORT_W | Asynchronous port pin levels |
| sleep | input | 1 | Sleep mode active |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 3 | Flag write data (0 clears a bit) |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 3 | Mask write data |
| en_stb | input | 1 | Enable-interrupts strobe |
| dis_stb | input | 1 | Disable-interrupts strobe |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | Core accepted an interrupt |
| flag_rd | output | 3 | Flags AND mask, registered |
| gie | output | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request |

## Verification
On every cycle, the assertions check that flags rise only in cycles that follow a hardware set, and that a hardware set always lands even when a clear arrives with it. They also check that read data never shows a bit the mask had cleared, that acceptance or disable always drops the enable, that a request is never raised without the enable, and that wake-up never appears outside sleep. Other behaviours can only be shown by the bench's scenarios. These are the exact clear-by-zero arithmetic across all write and mask values, the edge direction of the external pin, and the snapshot comparison for port changes against sleep entry. The bench also shows that wake-up occurs with the enable off.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_TMR  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_PCHG = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_V}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import irq_pkg::*;
#(
  parameter int PORT_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              sleep,
  output src_vec_t          hw_set,
  output logic              pin_chg
);
  logic              ext_s, ext_prev;
  logic [PORT_W-1:0] port_s, snap;
  logic              sleep_d;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s));

  irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_port_sync (
    .clk(clk), .rst(rst), .d(port_in), .q(port_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b1;
      sleep_d  <= 1'b0;
      snap     <= '0;
    end else begin
      ext_prev <= ext_s;
      sleep_d  <= sleep;
      if (sleep && !sleep_d) snap <= port_s;
    end
  end

  always_comb begin
    pin_chg            = sleep && sleep_d && (port_s != snap);
    hw_set             = '0;
    hw_set[SRC_TMR]    = tmr_ovf;
    hw_set[SRC_EXT]    = ext_prev && !ext_s;
    hw_set[SRC_PCHG]   = pin_chg;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t hw_set,
  input  logic     flag_wr,
  input  src_vec_t flag_wdata,
  input  logic     mask_wr,
  input  src_vec_t mask_wdata,
  output src_vec_t flag_q,
  output src_vec_t mask_q,
  output src_vec_t rd_q
);
  src_vec_t keep;

  always_comb keep = flag_wr ? flag_wdata : {NSRC{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
      rd_q   <= '0;
    end else begin
      flag_q <= (flag_q & keep) | hw_set;
      if (mask_wr) mask_q <= mask_wdata;
      rd_q   <= flag_q & mask_q;
    end
  end
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en_stb,
  input  logic     ret_stb,
  input  logic     dis_stb,
  input  logic     irq_ack,
  input  logic     sleep,
  input  logic     pin_chg,
  input  src_vec_t flag_q,
  input  src_vec_t mask_q,
  output logic     gie_q,
  output logic     irq_q,
  output logic     wake_q
);
  logic pend;

  always_comb pend = |(flag_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (dis_stb || irq_ack)     gie_q <= 1'b0;
      else if (en_stb || ret_stb) gie_q <= 1'b1;
      irq_q  <= gie_q && pend;
      wake_q <= sleep && (pin_chg || pend);
    end
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_pkg::*;
#(
  parameter int PORT_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              sleep,
  input  logic              flag_wr,
  input  logic [2:0]        flag_wdata,
  input  logic              mask_wr,
  input  logic [2:0]        mask_wdata,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              ret_stb,
  input  logic              irq_ack,
  output logic [2:0]        flag_rd,
  output logic              gie,
  output logic              irq_req,
  output logic              wake
);
  src_vec_t hw_set, flag_q, mask_q, rd_q;
  logic     pin_chg, gie_q, irq_q, wake_q;

  irq_src_detect #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_in(port_in), .sleep(sleep), .hw_set(hw_set), .pin_chg(pin_chg));

  irq_flag_reg u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .flag_q(flag_q), .mask_q(mask_q), .rd_q(rd_q));

  irq_gie_ctl u_ctl (
    .clk(clk), .rst(rst), .en_stb(en_stb), .ret_stb(ret_stb),
    .dis_stb(dis_stb), .irq_ack(irq_ack), .sleep(sleep), .pin_chg(pin_chg),
    .flag_q(flag_q), .mask_q(mask_q), .gie_q(gie_q), .irq_q(irq_q),
    .wake_q(wake_q));

  assign flag_rd = rd_q;
  assign gie     = gie_q;
  assign irq_req = irq_q;
  assign wake    = wake_q;
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk
  import irq_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input src_vec_t hw_set,
  input src_vec_t flag_q,
  input src_vec_t mask_q,
  input src_vec_t rd_q,
  input logic     dis_stb,
  input logic     irq_ack,
  input logic     gie_q,
  input logic     irq_q,
  input logic     sleep,
  input logic     wake_q
);
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (hw_set == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R4

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R5

  AST_RD_MASKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_q & ~$past(mask_q)) == '0)); // R6

  AST_GIE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dis_stb || irq_ack) |=> !gie_q); // R7

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!irq_q || $past(gie_q))); // R8

  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!wake_q || $past(sleep))); // R10
endmodule

bind irq_flag_unit irq_flag_unit_chk u_chk (
  .clk(clk), .rst(rst), .hw_set(hw_set), .flag_q(flag_q), .mask_q(mask_q),
  .rd_q(rd_q), .dis_stb(dis_stb), .irq_ack(irq_ack), .gie_q(gie_q),
  .irq_q(irq_q), .sleep(sleep), .wake_q(wake_q));

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
  localparam int PORT_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b1, tmr_ovf = 1'b0, sleep = 1'b0;
  logic [PORT_W-1:0] port_in = '0;
  logic flag_wr = 1'b0, mask_wr = 1'b0;
  logic [2:0] flag_wdata = '0, mask_wdata = '0;
  logic en_stb = 1'b0, dis_stb = 1'b0, ret_stb = 1'b0, irq_ack = 1'b0;
  logic [2:0] flag_rd;
  logic gie, irq_req, wake;

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  irq_flag_unit #(.PORT_W(PORT_W)) dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_in(port_in), .sleep(sleep), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .en_stb(en_stb), .dis_stb(dis_stb), .ret_stb(ret_stb), .irq_ack(irq_ack),
    .flag_rd(flag_rd), .gie(gie), .irq_req(irq_req), .wake(wake));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_flags(input logic [2:0] v);
    flag_wr = 1'b1; flag_wdata = v; tick(1); flag_wr = 1'b0; tick(2);
  endtask

  task automatic wr_mask(input logic [2:0] v);
    mask_wr = 1'b1; mask_wdata = v; tick(1); mask_wr = 1'b0; tick(2);
  endtask

  task automatic pulse_tmr();
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0; tick(2);
  endtask

  task automatic ext_fall();
    ext_pin = 1'b0; tick(5);
  endtask

  task automatic ext_rise();
    ext_pin = 1'b1; tick(5);
  endtask

  task automatic sleep_toggle();
    sleep = 1'b1; tick(4);
    port_in = port_in ^ 6'd1; tick(5);
    sleep = 1'b0; tick(2);
  endtask

  task automatic strobe(input int which);
    case (which)
      0: en_stb = 1'b1;
      1: ret_stb = 1'b1;
      2: dis_stb = 1'b1;
      default: irq_ack = 1'b1;
    endcase
    tick(1);
    en_stb = 1'b0; ret_stb = 1'b0; dis_stb = 1'b0; irq_ack = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 flag_rd", flag_rd, 0);
    chk("R1 gie", gie, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 wake", wake, 0);
    rst = 1'b0; tick(2);
    wr_mask(3'b111);
    chk("R1 flags zero after reset", flag_rd, 0);

    // R3 timer overflow
    pulse_tmr();
    chk("R3 timer flag", flag_rd, 3'b001);
    wr_flags(3'b000);

    // R2 falling edge sets, rising does not
    ext_fall();
    chk("R2 falling edge flag", flag_rd, 3'b010);
    wr_flags(3'b000);
    ext_rise();
    chk("R2 rising edge no flag", flag_rd, 0);

    // R9 port change while awake sets no flag
    port_in = 6'h2A; tick(5);
    chk("R9 awake change no flag", flag_rd, 0);
    // R9 sleep with no change: no wake, no flag
    sleep = 1'b1; tick(6);
    chk("R9 steady sleep wake", wake, 0);
    chk("R9 steady sleep flag", flag_rd, 0);
    port_in = 6'h2B; tick(5);
    chk("R9 change in sleep flag", flag_rd, 3'b100);
    chk("R9 change in sleep wake", wake, 1);
    sleep = 1'b0; tick(2);
    wr_flags(3'b000);
    chk("R10 wake low awake", wake, 0);

    // R5 hw set beats same-cycle clear
    tmr_ovf = 1'b1; flag_wr = 1'b1; flag_wdata = 3'b000; tick(1);
    tmr_ovf = 1'b0; flag_wr = 1'b0; tick(2);
    chk("R5 set wins over clear", flag_rd, 3'b001);
    wr_flags(3'b000);

    // R7 enable control
    strobe(0); chk("R7 en sets gie", gie, 1);
    strobe(2); chk("R7 dis clears gie", gie, 0);
    strobe(1); chk("R7 ret sets gie", gie, 1);
    strobe(3); chk("R7 ack clears gie", gie, 0);
    en_stb = 1'b1; irq_ack = 1'b1; tick(1);
    en_stb = 1'b0; irq_ack = 1'b0; tick(2);
    chk("R7 clear wins", gie, 0);
    ret_stb = 1'b1; dis_stb = 1'b1; tick(1);
    ret_stb = 1'b0; dis_stb = 1'b0; tick(2);
    chk("R7 dis beats ret", gie, 0);

    // R10 wake from unmasked flag with gie off
    wr_mask(3'b001);
    sleep = 1'b1; tick(4);
    pulse_tmr();
    chk("R10 wake with gie off", wake, 1);
    chk("R10 no irq with gie off", irq_req, 0);
    sleep = 1'b0; tick(2);
    wr_flags(3'b000);

    // R4 R6 R8 sweep of write and mask values
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 8; w++) begin
        wr_mask(3'b111);
        pulse_tmr(); ext_fall(); ext_rise(); sleep_toggle();
        chk("R4 all flags set", flag_rd, 7);
        wr_flags(w[2:0]);
        wr_flags(3'b111);
        wr_mask(m[2:0]);
        chk("R6 read masked", flag_rd, w & m);
        chk("R8 irq gie off", irq_req, 0);
        strobe(0);
        chk("R8 irq gie on", irq_req, ((w & m) != 0) ? 1 : 0);
        strobe(2);
        chk("R8 irq after dis", irq_req, 0);
        wr_mask(3'b111);
        chk("R4 write clears only zeros", flag_rd, w);
        wr_flags(3'b000);
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule